// File: doc/BRIEF.md
# Fine-Grain Join Copy Engine

This engine keeps a small table of join-node copies for a rule-matching network in which every two-input node is split into one copy per stored token. Each entry binds one node number to a single stored attribute value, the side that value arrived on, the node's relational test, the destination node for results, a generative flag and a negated-join flag. Tokens enter one at a time with a node number, a side, a polarity (add or delete) and an attribute value. The engine then walks the table one entry per clock. Entries holding a token from the opposite side run their test and emit result tokens. A same-side delete removes a copy. A same-side add makes the node's generative entry spawn a fresh copy.

A separate install command writes the generative entry of a node. That entry holds the node's test, type and destination, and also stores one token. For a negated join the left side is the positive input and the right side is the negated input. Every result the node produces from a match carries the inverted polarity. A left token also passes through before the scan, so that any cancelling token always follows it. Results leave on a valid/ready stream in the order in which they were produced.

Top module: `jn_engine`

## Requirements
- R1: After reset the table is empty, `out_valid` and `ovf` are 0 and `in_ready` is 1.
- R2: An install command (`in_install`=1) is taken in one cycle. It writes a generative entry that holds its token into the lowest-numbered free slot. If no slot is free it pulses `ovf` for one cycle and leaves the table unchanged.
- R3: For a token (`in_install`=0) the engine visits the entries in ascending slot order. Each entry of the same node that holds a token from the other side (side code 0 = left, 1 = right) computes `left op right`. When the test passes the entry emits a result with `out_node` equal to its destination, `out_lval`/`out_rval` equal to the left and right values, and `out_add` equal to the token's polarity (1 = add, 0 = delete) for a plain join.
- R4: The test codes are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than and 5 greater or equal, all unsigned. Codes 6 and 7 never pass.
- R5: A same-side delete removes only the lowest-numbered entry of that node whose stored value equals the token value. If that entry is the generative one, only its stored token is dropped: the entry stops testing and keeps spawning copies.
- R6: A same-side add, or any add when the node's generative entry holds a token from the other side, makes the generative entry write a new non-generative copy after the scan. The copy goes into the lowest free slot and holds the token and side. It takes part in the next token. A node without a generative entry gets no copy.
- R7: When R6 finds no free slot, `ovf` pulses for one cycle and no copy is written.
- R8: For a negated join, every result produced by a test match carries the inverse of the token's polarity.
- R9: For a negated join, a left token first emits a pass-through result (destination, token polarity, `out_lval` = token value, `out_rval` = 0) before any result of the scan.
- R10: A result stays on the output with its fields unchanged while `out_valid`=1 and `out_ready`=0. Results leave in the order in which they were produced.
- R11: `in_ready` is 1 only when no token is being processed and the output holds no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Engine idle and output drained |
| in_install | input | 1 | 1 = install a generative entry, 0 = token |
| in_node | input | NODE_W | Node number |
| in_side | input | 1 | 0 = left, 1 = right |
| in_add | input | 1 | Token polarity, 1 = add |
| in_val | input | VAL_W | Attribute value |
| in_op | input | 3 | Test code (install only) |
| in_neg | input | 1 | Negated-join flag (install only) |
| in_dest | input | NODE_W | Result destination (install only) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| out_node | output | NODE_W | Result destination node |
| out_add | output | 1 | Result polarity |
| out_lval | output | VAL_W | Left value |
| out_rval | output | VAL_W | Right value |
| ovf | output | 1 | One-cycle pulse: no free slot |

## Verification
The assertions assume that each node has at most one generative entry. The bench keeps to this by installing every node number once between resets, and its random tokens only address nodes installed that way or nodes with no entries at all. They also assume that a command is presented only while `in_ready` is high, which the bench drivers always wait for. The consumer's `out_ready` is left free, and the bench toggles it randomly so that the scan stalls behind a held result.

// File: rtl/jn_pkg.sv
// Shared encodings for the join copy engine.
// Assumes: side 0 is left, polarity 1 is add.
package jn_pkg;
    localparam logic SIDE_L = 1'b0;
    localparam logic SIDE_R = 1'b1;

    localparam logic [2:0] OP_EQ = 3'd0;
    localparam logic [2:0] OP_NE = 3'd1;
    localparam logic [2:0] OP_LT = 3'd2;
    localparam logic [2:0] OP_LE = 3'd3;
    localparam logic [2:0] OP_GT = 3'd4;
    localparam logic [2:0] OP_GE = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PASS = 3'd1,
        ST_SCAN = 3'd2,
        ST_DONE = 3'd3,
        ST_WAIT = 3'd4
    } jn_state_e;
endpackage

// File: rtl/jn_cmp.sv
// Relational test between a left and a right attribute value.
// Assumes unsigned values; codes outside the defined set never pass.
module jn_cmp
    import jn_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic [2:0]       op,
    input  logic [VAL_W-1:0] lval,
    input  logic [VAL_W-1:0] rval,
    output logic             pass
);
    // Evaluate the selected comparison
    always_comb begin
        case (op)
            OP_EQ:   pass = (lval == rval);
            OP_NE:   pass = (lval != rval);
            OP_LT:   pass = (lval <  rval);
            OP_LE:   pass = (lval <= rval);
            OP_GT:   pass = (lval >  rval);
            OP_GE:   pass = (lval >= rval);
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/jn_pick.sv
// Finds the lowest set bit of a request vector.
// Assumes N >= 2; idx is zero when nothing is set.
module jn_pick #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Priority search, lowest index wins
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/jn_outreg.sv
// Single-stage result register with valid/ready.
// Assumes the producer stalls whenever load_ok is low and it has data.
module jn_outreg #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         load_ok,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);
    assign load_ok = !out_valid || out_ready;

    // Load a new result when the slot is free or being drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else if (load_ok) begin
            out_valid <= push;
            if (push) dout <= din;
        end
    end
endmodule

// File: rtl/jn_engine.sv
// Join-node copy table with a one-entry-per-clock scan.
// Each token is processed to completion (pass-through, scan, copy
// creation, output drain) before the next command is accepted.
// Assumes at most one generative entry per node.
module jn_engine
    import jn_pkg::*;
#(
    parameter int NODE_W  = 6,
    parameter int VAL_W   = 8,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_install,
    input  logic [NODE_W-1:0] in_node,
    input  logic              in_side,
    input  logic              in_add,
    input  logic [VAL_W-1:0]  in_val,
    input  logic [2:0]        in_op,
    input  logic              in_neg,
    input  logic [NODE_W-1:0] in_dest,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NODE_W-1:0] out_node,
    output logic              out_add,
    output logic [VAL_W-1:0]  out_lval,
    output logic [VAL_W-1:0]  out_rval,
    output logic              ovf
);
    localparam int IW   = $clog2(ENTRIES);
    localparam int PW   = NODE_W + 1 + 2 * VAL_W;
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    // Table storage
    logic [ENTRIES-1:0] tbl_used;
    logic [ENTRIES-1:0] tbl_live;
    logic [ENTRIES-1:0] tbl_gen;
    logic [ENTRIES-1:0] tbl_side;
    logic [ENTRIES-1:0] tbl_neg;
    logic [2:0]         tbl_op   [ENTRIES];
    logic [NODE_W-1:0]  tbl_node [ENTRIES];
    logic [NODE_W-1:0]  tbl_dest [ENTRIES];
    logic [VAL_W-1:0]   tbl_val  [ENTRIES];

    // Token under processing
    jn_state_e          state;
    logic [IW-1:0]      idx;
    logic               del_done;
    logic [NODE_W-1:0]  t_node;
    logic               t_side;
    logic               t_add;
    logic [VAL_W-1:0]   t_val;

    // Finders
    logic [ENTRIES-1:0] gen_req;
    logic               gen_found, free_found;
    logic [IW-1:0]      gen_idx, free_idx;

    // Mark entries that are the generative copy of the current node
    for (genvar g = 0; g < ENTRIES; g++) begin : g_genreq
        assign gen_req[g] = tbl_used[g] && tbl_gen[g] && (tbl_node[g] == t_node);
    end

    jn_pick #(.N(ENTRIES)) u_gen_pick (
        .req   (gen_req),
        .found (gen_found),
        .idx   (gen_idx)
    );

    jn_pick #(.N(ENTRIES)) u_free_pick (
        .req   (~tbl_used),
        .found (free_found),
        .idx   (free_idx)
    );

    // Scan entry evaluation
    logic              ent_hit, ent_opp, test_ok;
    logic [VAL_W-1:0]  ent_l, ent_r;

    // Classify the entry under the scan pointer
    always_comb begin
        ent_hit = tbl_used[idx] && tbl_live[idx] && (tbl_node[idx] == t_node);
        ent_opp = (tbl_side[idx] != t_side);
        ent_l   = (tbl_side[idx] == SIDE_L) ? tbl_val[idx] : t_val;
        ent_r   = (tbl_side[idx] == SIDE_L) ? t_val : tbl_val[idx];
    end

    jn_cmp #(.VAL_W(VAL_W)) u_cmp (
        .op   (tbl_op[idx]),
        .lval (ent_l),
        .rval (ent_r),
        .pass (test_ok)
    );

    // Emission and output stage
    logic          emit_pass, emit_scan, emit, load_ok, advance, del_hit;
    logic [PW-1:0] res_din, res_dout;

    // Decide what, if anything, is emitted this cycle
    always_comb begin
        emit_pass = (state == ST_PASS) && gen_found && tbl_neg[gen_idx] && (t_side == SIDE_L);
        emit_scan = (state == ST_SCAN) && ent_hit && ent_opp && test_ok;
        emit      = emit_pass || emit_scan;
        advance   = !emit || load_ok;
        del_hit   = (state == ST_SCAN) && ent_hit && !ent_opp && !t_add
                    && !del_done && (tbl_val[idx] == t_val);
        if (emit_pass)
            res_din = {tbl_dest[gen_idx], t_add, t_val, {VAL_W{1'b0}}};
        else
            res_din = {tbl_dest[idx], t_add ^ tbl_neg[idx], ent_l, ent_r};
    end

    jn_outreg #(.W(PW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (emit),
        .din       (res_din),
        .load_ok   (load_ok),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dout      (res_dout)
    );

    assign {out_node, out_add, out_lval, out_rval} = res_dout;
    assign in_ready = (state == ST_IDLE);

    // Command sequencing and table updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            del_done <= 1'b0;
            ovf      <= 1'b0;
            t_node   <= '0;
            t_side   <= 1'b0;
            t_add    <= 1'b0;
            t_val    <= '0;
            tbl_used <= '0;
            tbl_live <= '0;
            tbl_gen  <= '0;
            tbl_side <= '0;
            tbl_neg  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_op[i]   <= '0;
                tbl_node[i] <= '0;
                tbl_dest[i] <= '0;
                tbl_val[i]  <= '0;
            end
        end else begin
            ovf <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_valid && in_install) begin
                        if (free_found) begin
                            tbl_used[free_idx] <= 1'b1;
                            tbl_live[free_idx] <= 1'b1;
                            tbl_gen[free_idx]  <= 1'b1;
                            tbl_side[free_idx] <= in_side;
                            tbl_neg[free_idx]  <= in_neg;
                            tbl_op[free_idx]   <= in_op;
                            tbl_node[free_idx] <= in_node;
                            tbl_dest[free_idx] <= in_dest;
                            tbl_val[free_idx]  <= in_val;
                        end else begin
                            ovf <= 1'b1;
                        end
                    end else if (in_valid) begin
                        t_node   <= in_node;
                        t_side   <= in_side;
                        t_add    <= in_add;
                        t_val    <= in_val;
                        idx      <= '0;
                        del_done <= 1'b0;
                        state    <= ST_PASS;
                    end
                end
                ST_PASS: begin
                    if (advance) state <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (advance) begin
                        if (del_hit) begin
                            if (tbl_gen[idx]) tbl_live[idx] <= 1'b0;
                            else              tbl_used[idx] <= 1'b0;
                            del_done <= 1'b1;
                        end
                        if (idx == LAST) state <= ST_DONE;
                        else             idx   <= idx + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (t_add && gen_found) begin
                        if (free_found) begin
                            tbl_used[free_idx] <= 1'b1;
                            tbl_live[free_idx] <= 1'b1;
                            tbl_gen[free_idx]  <= 1'b0;
                            tbl_side[free_idx] <= t_side;
                            tbl_neg[free_idx]  <= tbl_neg[gen_idx];
                            tbl_op[free_idx]   <= tbl_op[gen_idx];
                            tbl_node[free_idx] <= t_node;
                            tbl_dest[free_idx] <= tbl_dest[gen_idx];
                            tbl_val[free_idx]  <= t_val;
                        end else begin
                            ovf <= 1'b1;
                        end
                    end
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!out_valid || out_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/jn_engine_chk.sv
// Property checker for the join copy engine, bound to every instance.
// Assumes commands are only presented while in_ready is high.
module jn_engine_chk #(
    parameter int NODE_W  = 6,
    parameter int VAL_W   = 8,
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_install,
    input logic               out_valid,
    input logic               out_ready,
    input logic [NODE_W-1:0]  out_node,
    input logic               out_add,
    input logic [VAL_W-1:0]   out_lval,
    input logic [VAL_W-1:0]   out_rval,
    input logic               ovf,
    input logic [ENTRIES-1:0] used
);
    // R10: a stalled result keeps its fields
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_node) && $stable(out_add)
                                    && $stable(out_lval) && $stable(out_rval));

    // R10: a result only disappears after being taken
    a_r10_taken: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready));

    // R11: idle implies the output is drained
    a_r11_drained: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R11: an accepted token makes the engine busy
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_install |=> !in_ready);

    // R7: overflow only with a full table
    a_r7_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (&used));
endmodule

bind jn_engine jn_engine_chk #(
    .NODE_W (NODE_W),
    .VAL_W  (VAL_W),
    .ENTRIES(ENTRIES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_install (in_install),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_node   (out_node),
    .out_add    (out_add),
    .out_lval   (out_lval),
    .out_rval   (out_rval),
    .ovf        (ovf),
    .used       (tbl_used)
);

// File: tb/jn_engine_test.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural table model built from the
// requirements predicts every result list and overflow pulse.
module jn_engine_test;
    localparam int NW = 6;
    localparam int VW = 8;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_install = 1'b0, in_side = 1'b0, in_add = 1'b0, in_neg = 1'b0;
    logic [NW-1:0] in_node = '0, in_dest = '0;
    logic [VW-1:0] in_val = '0;
    logic [2:0]    in_op = '0;
    logic          in_ready, out_valid, out_add, ovf;
    logic          out_ready = 1'b1;
    logic [NW-1:0] out_node;
    logic [VW-1:0] out_lval, out_rval;

    int n_tests = 0, n_fail = 0;
    bit ready_free = 1'b1;

    // model
    bit m_used[NE], m_live[NE], m_gen[NE], m_side[NE], m_neg[NE];
    int m_op[NE], m_node[NE], m_dest[NE], m_val[NE];
    int exp_r[64], act_r[64];
    int ne_cnt, na_cnt, e_ovf, a_ovf;

    always #2 clk = ~clk;

    jn_engine #(.NODE_W(NW), .VAL_W(VW), .ENTRIES(NE)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_install(in_install), .in_node(in_node), .in_side(in_side), .in_add(in_add),
        .in_val(in_val), .in_op(in_op), .in_neg(in_neg), .in_dest(in_dest),
        .out_valid(out_valid), .out_ready(out_ready), .out_node(out_node), .out_add(out_add),
        .out_lval(out_lval), .out_rval(out_rval), .ovf(ovf)
    );

    // Consumer ready, changed just after each rising edge
    always @(posedge clk) begin
        #1 out_ready <= ready_free ? 1'b1 : ($urandom % 3 != 0);
    end

    // Record taken results and overflow pulses
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (na_cnt < 64) act_r[na_cnt] = {out_node, out_add, out_lval, out_rval};
            na_cnt++;
        end
        if (rst_n && ovf) a_ovf++;
    end

    function automatic bit f_cmp(input int op, input int a, input int b);
        case (op)
            0: return a == b;
            1: return a != b;
            2: return a <  b;
            3: return a <= b;
            4: return a >  b;
            5: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int f_pack(input int node, input int add, input int l, input int r);
        return (node << (1 + 2 * VW)) | (add << (2 * VW)) | (l << VW) | r;
    endfunction

    function automatic int f_free();
        for (int i = 0; i < NE; i++) if (!m_used[i]) return i;
        return -1;
    endfunction

    function automatic int f_gen(input int node);
        for (int i = 0; i < NE; i++) if (m_used[i] && m_gen[i] && m_node[i] == node) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input int v);
        if (ne_cnt < 64) exp_r[ne_cnt] = v;
        ne_cnt++;
    endtask

    task automatic m_install(input int node, input int side, input int val, input int op, input int neg, input int dest);
        int f;
        f = f_free();
        if (f < 0) e_ovf++;
        else begin
            m_used[f] = 1; m_live[f] = 1; m_gen[f] = 1; m_side[f] = side[0]; m_neg[f] = neg[0];
            m_op[f] = op; m_node[f] = node; m_dest[f] = dest; m_val[f] = val;
        end
    endtask

    task automatic m_token(input int node, input int side, input int add, input int val);
        int g, f, l, r;
        bit dd;
        dd = 0;
        g = f_gen(node);
        if (g >= 0 && m_neg[g] && side == 0) push_exp(f_pack(m_dest[g], add, val, 0));
        for (int i = 0; i < NE; i++) begin
            if (m_used[i] && m_live[i] && m_node[i] == node) begin
                if (int'(m_side[i]) != side) begin
                    l = (m_side[i] == 0) ? m_val[i] : val;
                    r = (m_side[i] == 0) ? val : m_val[i];
                    if (f_cmp(m_op[i], l, r)) push_exp(f_pack(m_dest[i], add ^ int'(m_neg[i]), l, r));
                end else if (add == 0 && !dd && m_val[i] == val) begin
                    if (m_gen[i]) m_live[i] = 0; else m_used[i] = 0;
                    dd = 1;
                end
            end
        end
        if (add != 0 && g >= 0) begin
            f = f_free();
            if (f < 0) e_ovf++;
            else begin
                m_used[f] = 1; m_live[f] = 1; m_gen[f] = 0; m_side[f] = side[0]; m_neg[f] = m_neg[g];
                m_op[f] = m_op[g]; m_node[f] = node; m_dest[f] = m_dest[g]; m_val[f] = val;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NE; i++) m_used[i] = 0;
        @(negedge clk);
    endtask

    // Issue one command, wait until drained, compare with the model
    task automatic do_cmd(input string tag, input bit inst, input int node, input int side,
                          input int add, input int val, input int op, input int neg, input int dest);
        ne_cnt = 0; na_cnt = 0; e_ovf = 0; a_ovf = 0;
        if (inst) m_install(node, side, val, op, neg, dest);
        else      m_token(node, side, add, val);
        @(negedge clk);
        in_valid = 1'b1; in_install = inst; in_node = NW'(node); in_side = side[0];
        in_add = add[0]; in_val = VW'(val); in_op = op[2:0]; in_neg = neg[0]; in_dest = NW'(dest);
        @(negedge clk);
        in_valid = 1'b0;
        while (!(in_ready && !out_valid)) @(negedge clk);
        @(negedge clk);
        chk(na_cnt == ne_cnt, tag, "result count", na_cnt, ne_cnt);
        for (int i = 0; i < ne_cnt && i < na_cnt && i < 64; i++)
            chk(act_r[i] == exp_r[i], tag, "result token", act_r[i], exp_r[i]);
        chk(a_ovf == e_ovf, tag, "overflow pulses", a_ovf, e_ovf);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        do_reset();
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        chk(ovf == 1'b0, "R1", "ovf", int'(ovf), 0);

        // R2, R3: plain join, test less-than, generative on the left
        do_cmd("R2", 1, 1, 0, 0, 3, 2, 0, 10);
        do_cmd("R3", 0, 1, 1, 1, 5, 0, 0, 0);
        chk(exp_r[0] == f_pack(10, 1, 3, 5), "R3", "model result", exp_r[0], f_pack(10, 1, 3, 5));
        // R6: copies spawned and active on the next token
        do_cmd("R6", 0, 1, 0, 1, 4, 0, 0, 0);
        // R5: same-side delete of a copy, opposite-side delete results
        do_cmd("R5", 0, 1, 1, 0, 5, 0, 0, 0);
        // R5: delete of the generative token keeps the entry
        do_cmd("R5", 0, 1, 0, 0, 3, 0, 0, 0);
        do_cmd("R6", 0, 1, 1, 1, 6, 0, 0, 0);
        // R6: node without generative entry
        do_cmd("R6", 0, 33, 0, 1, 6, 0, 0, 0);

        // R4: every test code
        do_reset();
        for (int op = 0; op < 8; op++) do_cmd("R4", 1, 8 + op, 0, 0, 5, op, 0, 40 + op);
        for (int op = 0; op < 8; op++)
            for (int v = 4; v <= 6; v++) do_cmd("R4", 0, 8 + op, 1, 0, v, 0, 0, 0);

        // R8, R9: negated join, generative on the negated side
        do_reset();
        ready_free = 1'b0;
        do_cmd("R2", 1, 20, 1, 0, 7, 0, 1, 30);
        do_cmd("R9", 0, 20, 0, 1, 7, 0, 0, 0);
        chk(exp_r[0] == f_pack(30, 1, 7, 0) && exp_r[1] == f_pack(30, 0, 7, 7), "R9", "model order",
            exp_r[1], f_pack(30, 0, 7, 7));
        do_cmd("R9", 0, 20, 0, 1, 2, 0, 0, 0);
        do_cmd("R8", 0, 20, 1, 1, 2, 0, 0, 0);
        do_cmd("R8", 0, 20, 1, 0, 2, 0, 0, 0);
        do_cmd("R8", 0, 20, 0, 0, 7, 0, 0, 0);

        // R7: fill the table, then overflow on copy and on install
        do_reset();
        do_cmd("R2", 1, 5, 0, 0, 1, 4, 0, 9);
        for (int i = 0; i < 15; i++) do_cmd("R6", 0, 5, 0, 1, i, 0, 0, 0);
        do_cmd("R7", 0, 5, 1, 1, 3, 0, 0, 0);
        do_cmd("R7", 1, 6, 0, 0, 1, 0, 0, 9);
        do_cmd("R3", 0, 5, 1, 0, 0, 0, 0, 0);

        // R10, R11: random traffic with a stalling consumer
        do_reset();
        for (int n = 0; n < 4; n++)
            do_cmd("R2", 1, n, $urandom % 2, 0, $urandom % 8, $urandom % 8, $urandom % 2, 50 + n);
        for (int k = 0; k < 300; k++)
            do_cmd("R10", 0, $urandom % 5, $urandom % 2, ($urandom % 10) < 7, $urandom % 8, 0, 0, 0);
        chk(in_ready == 1'b1, "R11", "in_ready after traffic", int'(in_ready), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule